// File: doc/BRIEF.md
# SIMD Chunk Permute and Select Unit

This execution-unit datapath rearranges the equal-width chunks of a 64-bit source word. The chunk width is picked for each operation: 8, 16, 32 or 64 bits, which gives 8, 4, 2 or 1 chunks. In permute mode, every result chunk is loaded with the source chunk whose number is held in the matching chunk of a selector word. In select mode, only one chunk is chosen, and it is placed zero-extended at the bottom of the result. Each mode also has an immediate form that takes the chunk number from an 8-bit unsigned immediate instead of the selector word. The immediate permute form therefore copies the chosen chunk into every position.

An index is always cut down to the bits needed to count the chunks: three bits with 8 chunks and none with a single chunk. An all-zero selector therefore copies the lowest chunk into every slot. The result is registered, so it appears one clock after the operands, and a valid flag follows the input valid.

Top module: `chunk_perm_unit`

## Requirements
- R1: With opcode 2'b00 (permute), result chunk i equals source chunk k, where k is the index held in selector chunk i, for every chunk i. Chunk i occupies bits [i*W +: W] for chunk width W.
- R2: Only the low log2(N) bits of a selector chunk or of the immediate form the index, where N is the chunk count. All higher bits have no effect on the result.
- R3: With opcode 2'b01 (select), result bits [W-1:0] equal the source chunk indexed by selector chunk 0. All result bits above W are zero.
- R4: With opcode 2'b10 (select-immediate), the result is as for R3, but the index comes from the 8-bit immediate.
- R5: A permute with an all-zero selector puts a copy of source chunk 0 into every result chunk.
- R6: With size code 2'b11 (one 64-bit chunk), the result equals the source word for every opcode.
- R7: With opcode 2'b11 (permute-immediate), every result chunk equals the source chunk indexed by the immediate.
- R8: The size code maps 2'b00 to 8-bit chunks, 2'b01 to 16-bit chunks, 2'b10 to 32-bit chunks and 2'b11 to 64-bit chunks.
- R9: `out_valid` equals `in_valid` delayed by one clock. The result for operands presented with `in_valid` high appears on the clock edge that raises `out_valid`.
- R10: While `rst` is high at a clock edge, `out_valid` and `result` are cleared to zero.
- R11: A cycle with `in_valid` low leaves `result` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| opcode | input | 2 | Operation: 00 permute, 01 select, 10 select-immediate, 11 permute-immediate |
| size | input | 2 | Chunk width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| sel_word | input | 64 | Selector operand |
| src_word | input | 64 | Source operand |
| imm | input | 8 | Unsigned immediate index |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Registered result word |

## Verification
A wrong lane index, for example one with a lost offset inside a chunk or a missing index mask, sends a wrong byte to at least one result lane. That wrong byte is visible on the very next clock after the operands are accepted. A zero-extension fault in select mode shows as nonzero upper bits in that same cycle. A broken hold or valid pipeline shows as a changed `result` or a wrong `out_valid` one clock after an idle cycle. Random vectors over all opcode and size pairs are compared against a model of the chunk loop. Directed cases cover the all-zero selector, set high index bits and the single-chunk size.

// File: rtl/chunk_perm_pkg.sv
package chunk_perm_pkg;
  localparam int DATA_W  = 64;
  localparam int LANE_W  = 8;
  localparam int NLANES  = DATA_W / LANE_W;
  localparam int LSEL_W  = $clog2(NLANES);
  localparam int IMM_W   = 8;
  localparam int SIZE_W  = 2;

  typedef enum logic [1:0] {
    OP_PERM  = 2'b00,
    OP_SEL   = 2'b01,
    OP_SELI  = 2'b10,
    OP_PERMI = 2'b11
  } perm_op_e;

  typedef enum logic [SIZE_W-1:0] {
    CH_8  = 2'b00,
    CH_16 = 2'b01,
    CH_32 = 2'b10,
    CH_64 = 2'b11
  } chunk_size_e;
endpackage

// File: rtl/chunk_lane_ctrl.sv
// Works out, for every output byte lane, which source lane feeds it and
// whether the lane is forced to zero (upper chunks in select modes).
module chunk_lane_ctrl
  import chunk_perm_pkg::*;
#(
  parameter int NL    = NLANES,
  parameter int LW    = LANE_W,
  parameter int SW    = SIZE_W,
  parameter int IW    = IMM_W,
  localparam int LSW  = $clog2(NL)
) (
  input  logic [SW-1:0]          size_i,
  input  logic [1:0]             op_i,
  input  logic [NL*LW-1:0]       sel_i,
  input  logic [IW-1:0]          imm_i,
  output logic [NL-1:0][LSW-1:0] src_lane_o,
  output logic [NL-1:0]          lane_zero_o
);

  // A chunk may hold at most every lane of the word.
  localparam int MAX_SIZE = (1 << SW) - 1;
  initial begin
    if (MAX_SIZE > LSW) $display("chunk_lane_ctrl: size code exceeds lane count");
  end

  function automatic logic [LSW-1:0] lane_source(
    input int          lane,
    input logic [SW-1:0] sz_code,
    input logic [1:0]  op,
    input logic [NL*LW-1:0] sel,
    input logic [IW-1:0] imm
  );
    int sz, off, cnum, base, raw, nmask, k;
    sz    = int'(sz_code);
    off   = lane & ((1 << sz) - 1);
    cnum  = lane >> sz;
    base  = cnum << sz;
    case (perm_op_e'(op))
      OP_PERM:  raw = int'(sel[base*LW +: LW]);
      OP_SEL:   raw = int'(sel[LW-1:0]);
      default:  raw = int'(imm);
    endcase
    nmask = (1 << (LSW - sz)) - 1;
    k     = raw & nmask;
    return LSW'((k << sz) | off);
  endfunction

  for (genvar b = 0; b < NL; b++) begin : g_lane
    always_comb begin
      src_lane_o[b]  = lane_source(b, size_i, op_i, sel_i, imm_i);
      lane_zero_o[b] = ((perm_op_e'(op_i) == OP_SEL) || (perm_op_e'(op_i) == OP_SELI))
                       && ((b >> int'(size_i)) != 0);
    end

    // The offset of the lane inside its chunk never changes (R1).
    always_comb begin
      assert_lane_offset_R1: assert ((int'(src_lane_o[b]) & ((1 << int'(size_i)) - 1))
                                     == (b & ((1 << int'(size_i)) - 1)));
    end
  end

endmodule

// File: rtl/chunk_lane_mux.sv
// One multiplexer per output lane with a zero-force for select modes.
module chunk_lane_mux #(
  parameter int NL   = 8,
  parameter int LW   = 8,
  localparam int LSW = $clog2(NL)
) (
  input  logic [NL*LW-1:0]       src_i,
  input  logic [NL-1:0][LSW-1:0] src_lane_i,
  input  logic [NL-1:0]          lane_zero_i,
  output logic [NL*LW-1:0]       y_o
);

  for (genvar b = 0; b < NL; b++) begin : g_mux
    logic [LW-1:0] picked;
    always_comb begin
      picked = src_i[int'(src_lane_i[b])*LW +: LW];
      y_o[b*LW +: LW] = lane_zero_i[b] ? '0 : picked;
    end

    // A zero-forced lane must never carry data.
    always_comb begin
      assert_zero_lane_R3: assert (!lane_zero_i[b] || (y_o[b*LW +: LW] == '0));
    end
  end

endmodule

// File: rtl/chunk_perm_unit.sv
module chunk_perm_unit
  import chunk_perm_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int LW  = LANE_W,
  parameter int SW  = SIZE_W,
  parameter int IW  = IMM_W,
  localparam int NL  = DW / LW,
  localparam int LSW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    opcode,
  input  logic [SW-1:0] size,
  input  logic [DW-1:0] sel_word,
  input  logic [DW-1:0] src_word,
  input  logic [IW-1:0] imm,
  output logic          out_valid,
  output logic [DW-1:0] result
);

  logic [NL-1:0][LSW-1:0] src_lane;
  logic [NL-1:0]          lane_zero;
  logic [DW-1:0]          y_comb;

  chunk_lane_ctrl #(.NL(NL), .LW(LW), .SW(SW), .IW(IW)) u_ctrl (
    .size_i      (size),
    .op_i        (opcode),
    .sel_i       (sel_word),
    .imm_i       (imm),
    .src_lane_o  (src_lane),
    .lane_zero_o (lane_zero)
  );

  chunk_lane_mux #(.NL(NL), .LW(LW)) u_mux (
    .src_i       (src_word),
    .src_lane_i  (src_lane),
    .lane_zero_i (lane_zero),
    .y_o         (y_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= y_comb;
    end
  end

  assert_valid_rise_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_fall_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  assert_select_zext_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode == OP_SEL || opcode == OP_SELI) && size == CH_8)
      |=> (result[DW-1:LW] == '0));
  assert_single_chunk_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && size == CH_64) |=> (result == $past(src_word)));
  assert_zero_sel_bcast_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OP_PERM && sel_word == '0 && size == CH_8)
      |=> (result == {NL{$past(src_word[LW-1:0])}}));

endmodule

// File: tb/tb_chunk_perm_unit.sv
`timescale 1ns/1ps
module tb_chunk_perm_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  opcode;
  logic [1:0]  size;
  logic [63:0] sel_word, src_word;
  logic [7:0]  imm;
  logic        out_valid;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [63:0] last_res;

  always #4 clk = ~clk;

  chunk_perm_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .size(size),
    .sel_word(sel_word), .src_word(src_word), .imm(imm),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [63:0] model(input logic [1:0] op, input logic [1:0] sz,
                                        input logic [63:0] sel, input logic [63:0] src,
                                        input logic [7:0] im);
    logic [63:0] y = '0;
    int cw = 8 << sz;
    int n  = 64 / cw;
    for (int i = 0; i < n; i++) begin
      int k;
      case (op)
        2'b00: k = int'((sel >> (i*cw)) & 64'(n-1));
        2'b01: k = int'(sel & 64'(n-1));
        default: k = int'(im) & (n-1);
      endcase
      if (op == 2'b01 || op == 2'b10) begin
        if (i != 0) continue;
      end
      for (int j = 0; j < cw; j++) y[i*cw+j] = src[k*cw+j];
    end
    return y;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic v, input logic [1:0] op,
                       input logic [1:0] sz, input logic [63:0] sel,
                       input logic [63:0] src, input logic [7:0] im);
    logic [63:0] exp;
    @(negedge clk);
    last_res = result;
    in_valid = v; opcode = op; size = sz; sel_word = sel; src_word = src; imm = im;
    exp = v ? model(op, sz, sel, src, im) : last_res;
    @(negedge clk);
    check({tag, " R9 valid"}, {63'd0, out_valid}, {63'd0, v});
    check(tag, result, exp);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<100000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0] s;
    s = 64'h8877_6655_4433_2211;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; opcode = '0; size = '0;
    sel_word = '0; src_word = '1; imm = '0;
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 reset result", result, 64'd0);
    @(negedge clk); rst = 1'b0;

    apply("R5 zero selector broadcast b8", 1, 2'b00, 2'b00, 64'd0, s, 8'd0);
    check("R5 explicit", result, {8{8'h11}});
    apply("R1 byte reverse", 1, 2'b00, 2'b00, 64'h0001_0203_0405_0607, s, 8'd0);
    check("R1 explicit", result, 64'h1122_3344_5566_7788);
    apply("R2 high index bits ignored b8", 1, 2'b00, 2'b00, 64'hF9FA_FBFC_FDFE_FFF8, s, 8'd0);
    apply("R8 R1 16-bit swap", 1, 2'b00, 2'b01, 64'h0000_0001_0002_0003, s, 8'd0);
    check("R8 explicit h16", result, 64'h2211_4433_6655_8877);
    apply("R3 select b16 idx 2 with high bits", 1, 2'b01, 2'b01, 64'h0000_0000_0000_FFFE, s, 8'd0);
    check("R3 explicit", result, 64'h0000_0000_0000_6655);
    apply("R4 select imm h32 imm FF", 1, 2'b10, 2'b10, 64'd0, s, 8'hFF);
    check("R4 R2 explicit", result, 64'h0000_0000_8877_6655);
    apply("R7 permi b8 imm 5", 1, 2'b11, 2'b00, 64'h0, s, 8'h0D);
    check("R7 explicit", result, {8{8'h66}});
    for (int op = 0; op < 4; op++)
      apply("R6 single chunk passthrough", 1, 2'(op), 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, s, 8'hFF);
    apply("R11 idle hold", 0, 2'b01, 2'b00, 64'h3, 64'h0, 8'd0);
    check("R11 explicit", result, s);

    for (int t = 0; t < 400; t++) begin
      logic [1:0] op, sz;
      op = 2'($urandom); sz = 2'($urandom);
      apply(op == 2'b00 ? "R1 R2 random permute" : op == 2'b01 ? "R3 random select" :
            op == 2'b10 ? "R4 random select-imm" : "R7 random permi",
            ($urandom % 8) != 0, op, sz, {$urandom, $urandom}, {$urandom, $urandom},
            8'($urandom));
    end

    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R10 mid-run reset", result, 64'd0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule